// File: doc/BRIEF.md
# Width-Downsizing Dual-Clock FIFO

This block carries 36-bit entries from a write clock domain to a read clock domain. The two clocks may be unrelated. On the read side it hands each entry out in narrower pieces on an 18-bit bus. In word mode each entry becomes two 18-bit halves. In byte mode it becomes four 9-bit bytes, presented on the low nine bits of the bus. A configuration input picks which end of the entry comes out first. The storage holds 256 entries. Pointers cross between the clock domains in Gray code through two-flop synchronizers. Full and almost-full are computed on the write side, and empty and almost-empty on the read side.

Two flag disciplines are available. In standard timing the status pins mean "empty" and "full", and a read loads the output register one read-clock edge later. In fall-through timing the same pins mean "output ready" and "input ready", and the piece at the head is already present on the read bus before any read is requested. A single offset controls both almost flags. It is picked from three presets.

The master reset flushes the data and captures the configuration pins (timing mode, piece order, piece size and offset preset). The partial reset flushes the data but leaves the captured configuration as it was. On the read side a four-state piece sequencer (`PH_0`, `PH_1`, `PH_2`, `PH_3`) tracks which piece of the head entry is due:

- `PH_0 -> PH_1` on a read.
- `PH_1 -> PH_0` on a read in word mode, or `PH_1 -> PH_2` in byte mode.
- `PH_2 -> PH_3` on a read.
- `PH_3 -> PH_0` on a read.

Every state holds its value when no read happens. Either reset returns the sequencer to `PH_0`.

Top module: `bmf_fifo_top`

## Requirements
- R1: A 36-bit entry is stored on a rising `wclk` edge when `wr_en` is high and the FIFO is not full. A piece is consumed on a rising `rclk` edge when `rd_en` is high and the FIFO is not empty. Writes and reads may happen on the same edges, and the two clocks are independent.
- R2: In word mode (`cfg_byte`=0 captured), each entry is delivered as exactly two 18-bit pieces on `rd_data[17:0]`.
- R3: In byte mode (`cfg_byte`=1 captured), each entry is delivered as four 9-bit pieces on `rd_data[8:0]`, and `rd_data[17:9]` reads 0.
- R4: With `cfg_big_end`=1 captured, the order is bits [35:18] then [17:0] in word mode. In byte mode it is [35:27], [26:18], [17:9], [8:0].
- R5: With `cfg_big_end`=0 captured, the order is reversed. In word mode it is [17:0] then [35:18]. In byte mode it is [8:0], [17:9], [26:18], [35:27].
- R6: An entry leaves the storage only after its last piece is read. While any piece of an entry is still unread, the FIFO does not report empty.
- R7: Standard timing (`cfg_fwft`=0 captured): `rflag`=1 means empty and `wflag`=1 means full. `rd_data` is a register that takes the requested piece on the `rclk` edge that accepts the read, and holds it otherwise.
- R8: Fall-through timing (`cfg_fwft`=1 captured): `rflag`=1 means a piece is ready and `wflag`=1 means space is free. The head piece is shown on `rd_data` without a read, and a read moves to the next piece.
- R9: `almost_empty` is 1 when the stored entry count is at or below the offset. `almost_full` is 1 when the free entry count is at or below the offset.
- R10: The offset comes from `cfg_ofs_sel`, captured at master reset: 0 gives 8, 1 gives 16, and 2 or 3 gives 64.
- R11: While `mrst_n` is low, the FIFO empties, the piece sequencer returns to `PH_0`, and `cfg_fwft`, `cfg_big_end`, `cfg_byte` and `cfg_ofs_sel` are captured.
- R12: While `prst_n` is low, the FIFO empties and the sequencer returns to `PH_0`. The previously captured configuration is kept.
- R13: A write while full and a read while empty are ignored. Pointers, stored data, sequencer state and the standard-timing output register do not change.
- R14: The storage holds 256 entries. The FIFO reports full after 256 unread writes, and not after 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, held for several cycles of both clocks |
| prst_n | input | 1 | Partial reset, active low, held for several cycles of both clocks |
| cfg_fwft | input | 1 | 1 selects fall-through timing, captured at master reset |
| cfg_big_end | input | 1 | 1 selects high-end-first order, captured at master reset |
| cfg_byte | input | 1 | 1 selects 9-bit pieces, 0 selects 18-bit pieces, captured at master reset |
| cfg_ofs_sel | input | 2 | Almost-flag offset preset, captured at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Entry to store |
| wflag | output | 1 | Full (standard timing) or input ready (fall-through) |
| almost_full | output | 1 | Free space at or below the offset |
| rd_en | input | 1 | Piece read request |
| rd_data | output | 18 | Delivered piece |
| rflag | output | 1 | Empty (standard timing) or output ready (fall-through) |
| almost_empty | output | 1 | Stored entries at or below the offset |

## Verification
The unpacking path is tested in all four combinations of piece size and piece order. Each is run in a different timing mode, so a swapped half, a wrong byte slice, a stale output register or a missing fall-through look-ahead each show up as a wrong piece. Constrained-random bursts with gaps on both sides, under unrelated clock periods, exercise pointer synchronization while the FIFO both drains to empty and fills up. Directed sequences cover the threshold edges: the almost flags one entry on either side of each preset offset, full at 255 versus 256 entries, and a write attempted while full. Other directed cases cover reads attempted while empty, the unfinished-entry case of R6, and a partial reset taken while the configuration pins are driven to other values, which separates "config kept" from "config reloaded".

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    function automatic logic [15:0] ofs_decode(input logic [1:0] sel);
        logic [15:0] v;
        case (sel)
            2'd0:    v = 16'd8;
            2'd1:    v = 16'd16;
            default: v = 16'd64;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bmf_sync.sv
module bmf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bmf_ram.sv
module bmf_ram #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bmf_wr_ctl.sv
module bmf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic [1:0]    cfg_ofs_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          full,
    output logic          afull,
    output logic          fwft_q
);
    localparam int PW = AW + 1;
    localparam logic [AW:0] DEPTH_V = PW'(1 << AW);

    logic          rst;
    logic [AW:0]   wbin, wbin_nx, rbin_s, used, free_n, ofs_q;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign rst = !mrst_n || !prst_n;

    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            fwft_q <= cfg_fwft;
            ofs_q  <= PW'(bmf_pkg::ofs_decode(cfg_ofs_sel));
        end
    end

    assign rbin_s  = g2b(rgray_s);
    assign used    = wbin - rbin_s;
    assign free_n  = DEPTH_V - used;
    assign full    = (used == DEPTH_V);
    assign afull   = (free_n <= ofs_q);
    assign we      = wr_en && !full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + PW'(we);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // R13: a write refused while full leaves the write pointer alone
    a_r13_wr_ignored_full: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && full) |=> (wbin == $past(wbin)));
    // R14: never more than DEPTH entries outstanding
    a_r14_no_overfill: assert property (@(posedge wclk) disable iff (rst)
        used <= DEPTH_V);
    // R1: the pointer seen by the other domain moves one Gray bit at a time
    a_r1_gray_step: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    // R9: full implies almost-full
    a_r9_full_implies_af: assert property (@(posedge wclk) disable iff (rst)
        full |-> afull);
endmodule

// File: rtl/bmf_rd_ctl.sv
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 36,
    parameter int OW = 18
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_big_end,
    input  logic          cfg_byte,
    input  logic [1:0]    cfg_ofs_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] head,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [OW-1:0] rd_data,
    output logic          empty,
    output logic          aempty,
    output logic          fwft_q
);
    localparam int PW = AW + 1;
    localparam int BW = OW / 2;

    logic          rst, be_q, byte_q, take, last_piece;
    logic [AW:0]   rbin, rbin_inc, wbin_s, stored, ofs_q;
    logic [OW-1:0] dreg, cur, word_v;
    logic [BW-1:0] byte_v;
    logic [1:0]    idx, bsel;
    logic          wsel;
    phase_e        ph_q, ph_d;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign rst = !mrst_n || !prst_n;

    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            fwft_q <= cfg_fwft;
            be_q   <= cfg_big_end;
            byte_q <= cfg_byte;
            ofs_q  <= PW'(ofs_decode(cfg_ofs_sel));
        end
    end

    assign wbin_s     = g2b(wgray_s);
    assign stored     = wbin_s - rbin;
    assign empty      = (stored == '0);
    assign aempty     = (stored <= ofs_q);
    assign take       = rd_en && !empty;
    assign last_piece = byte_q ? (ph_q == PH_3) : (ph_q == PH_1);
    assign rbin_inc   = rbin + PW'(1);
    assign raddr      = rbin[AW-1:0];

    // piece sequencer: next state
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_0: if (take) ph_d = PH_1;
            PH_1: if (take) ph_d = byte_q ? PH_2 : PH_0;
            PH_2: if (take) ph_d = PH_3;
            PH_3: if (take) ph_d = PH_0;
        endcase
    end

    // piece sequencer: state register
    always_ff @(posedge rclk) begin
        if (rst) ph_q <= PH_0;
        else     ph_q <= ph_d;
    end

    // piece selection from the head entry
    assign idx    = ph_q;
    assign wsel   = be_q ? ~idx[0] : idx[0];
    assign bsel   = be_q ? (2'd3 - idx) : idx;
    assign word_v = wsel ? head[DW-1 -: OW] : head[OW-1:0];
    assign byte_v = head[int'(bsel) * BW +: BW];
    assign cur    = byte_q ? {{(OW-BW){1'b0}}, byte_v} : word_v;

    // outputs: read pointer and registered piece
    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            dreg  <= '0;
        end else begin
            if (take) dreg <= cur;
            if (take && last_piece) begin
                rbin  <= rbin_inc;
                rgray <= rbin_inc ^ (rbin_inc >> 1);
            end
        end
    end

    assign rd_data = fwft_q ? cur : dreg;

    // R13: a read refused while empty changes neither pointer nor sequencer
    a_r13_rd_ignored_empty: assert property (@(posedge rclk) disable iff (rst)
        (rd_en && empty) |=> (rbin == $past(rbin) && ph_q == $past(ph_q)));
    // R6: the read pointer moves only out of the final phase
    a_r6_pop_on_last: assert property (@(posedge rclk) disable iff (rst)
        (rbin != $past(rbin)) |-> ($past(ph_q) == (byte_q ? PH_3 : PH_1)));
    // R2: word mode never leaves the first two phases
    a_r2_word_phases: assert property (@(posedge rclk) disable iff (rst)
        !byte_q |-> (ph_q == PH_0 || ph_q == PH_1));
    // R9: empty implies almost-empty
    a_r9_empty_implies_ae: assert property (@(posedge rclk) disable iff (rst)
        empty |-> aempty);
    // R7: in standard timing the output register holds without an accepted read
    a_r7_hold_dreg: assert property (@(posedge rclk) disable iff (rst)
        !$past(take) |-> $stable(dreg));
endmodule

// File: rtl/bmf_fifo_top.sv
module bmf_fifo_top #(
    parameter int AW = 8,
    parameter int DW = 36,
    parameter int OW = 18
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_big_end,
    input  logic          cfg_byte,
    input  logic [1:0]    cfg_ofs_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wflag,
    output logic          almost_full,
    input  logic          rd_en,
    output logic [OW-1:0] rd_data,
    output logic          rflag,
    output logic          almost_empty
);
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] head;
    logic          we, full, empty, w_fwft, r_fwft, wrst, rrst;

    assign wrst = !mrst_n || !prst_n;
    assign rrst = wrst;

    bmf_wr_ctl #(.AW(AW)) u_wr (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_ofs_sel(cfg_ofs_sel),
        .wr_en(wr_en), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
        .we(we), .full(full), .afull(almost_full), .fwft_q(w_fwft)
    );

    bmf_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(head)
    );

    bmf_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    bmf_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
    );

    bmf_rd_ctl #(.AW(AW), .DW(DW), .OW(OW)) u_rd (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_big_end(cfg_big_end), .cfg_byte(cfg_byte),
        .cfg_ofs_sel(cfg_ofs_sel), .rd_en(rd_en), .wgray_s(wgray_s),
        .head(head), .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
        .empty(empty), .aempty(almost_empty), .fwft_q(r_fwft)
    );

    assign wflag = w_fwft ? !full : full;
    assign rflag = r_fwft ? !empty : empty;
endmodule

// File: tb/bmf_fifo_top_tb_top.sv
module bmf_fifo_top_tb_top;
    logic        wclk = 0, rclk = 0;
    logic        mrst_n = 0, prst_n = 1;
    logic        cfg_fwft = 0, cfg_big_end = 1, cfg_byte = 0;
    logic [1:0]  cfg_ofs_sel = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [35:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        wflag, almost_full, rflag, almost_empty;

    int n_checks = 0, n_fail = 0;
    bit cur_fwft, cur_be, cur_byte;
    logic [35:0] q[$];
    int pidx = 0;

    bmf_fifo_top dut_i (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_big_end(cfg_big_end), .cfg_byte(cfg_byte),
        .cfg_ofs_sel(cfg_ofs_sel), .wr_en(wr_en), .wr_data(wr_data),
        .wflag(wflag), .almost_full(almost_full), .rd_en(rd_en),
        .rd_data(rd_data), .rflag(rflag), .almost_empty(almost_empty)
    );

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [17:0] piece_of(input logic [35:0] e, input int i, input bit be, input bit byt);
        int k;
        if (byt) begin
            k = be ? 3 - i : i;
            return {9'd0, e[k*9 +: 9]};
        end
        k = be ? 1 - i : i;
        return e[k*18 +: 18];
    endfunction

    function automatic int npieces();
        return cur_byte ? 4 : 2;
    endfunction

    function automatic bit is_full();
        return cur_fwft ? !wflag : wflag;
    endfunction

    function automatic bit is_empty();
        return cur_fwft ? !rflag : rflag;
    endfunction

    function automatic logic [17:0] next_piece();
        return piece_of(q[0], pidx, cur_be, cur_byte);
    endfunction

    task automatic advance();
        pidx++;
        if (pidx == npieces()) begin
            void'(q.pop_front());
            pidx = 0;
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic master_reset(input bit f, input bit be, input bit byt, input logic [1:0] sel);
        cfg_fwft = f; cfg_big_end = be; cfg_byte = byt; cfg_ofs_sel = sel;
        mrst_n = 0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        mrst_n = 1;
        cur_fwft = f; cur_be = be; cur_byte = byt;
        q.delete(); pidx = 0;
        settle();
    endtask

    task automatic write_n(input int n, input int pct);
        int done = 0;
        while (done < n) begin
            @(negedge wclk);
            wr_en = 0;
            if (!is_full() && ($urandom % 100) < pct) begin
                wr_en = 1;
                wr_data = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
                q.push_back(wr_data);
                done++;
            end
        end
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic read_n(input int n, input int pct, input string req);
        int done = 0;
        bit pend = 0;
        logic [17:0] exp = '0;
        while (done < n || pend) begin
            @(negedge rclk);
            if (pend) begin
                chk(rd_data == exp, req, 36'(rd_data), 36'(exp));
                pend = 0;
            end
            rd_en = 0;
            if (done < n && !is_empty() && q.size() > 0 && ($urandom % 100) < pct) begin
                if (!cur_fwft) begin
                    exp = next_piece();
                    pend = 1;
                end else begin
                    chk(rd_data == next_piece(), req, 36'(rd_data), 36'(next_piece()));
                end
                rd_en = 1;
                advance();
                done++;
            end
        end
        @(negedge rclk);
        rd_en = 0;
    endtask

    task automatic traffic(input int n, input string req);
        int np;
        np = npieces();
        fork
            write_n(n, 60);
            read_n(n * np, 55, req);
        join
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [17:0] held;
        void'($urandom(32'd20240611));

        // R11 R7: reset state, standard timing, word, high end first
        master_reset(0, 1, 0, 2'd0);
        chk(rflag == 1, "R11 empty after master reset", 36'(rflag), 1);
        chk(wflag == 0, "R11 not full after master reset", 36'(wflag), 0);
        chk(almost_empty == 1, "R9 ae at reset", 36'(almost_empty), 1);
        chk(almost_full == 0, "R9 af at reset", 36'(almost_full), 0);
        chk(rd_data == 0, "R7 output register cleared", 36'(rd_data), 0);

        // R6: half-read entry still present
        write_n(1, 100);
        settle();
        read_n(1, 100, "R4 first half");
        settle();
        chk(rflag == 0, "R6 not empty with one piece left", 36'(rflag), 0);
        read_n(1, 100, "R4 second half");
        settle();
        chk(rflag == 1, "R6 empty after last piece", 36'(rflag), 1);

        // R13: reads while empty ignored
        held = rd_data;
        @(negedge rclk); rd_en = 1;
        repeat (3) @(negedge rclk);
        rd_en = 0;
        @(negedge rclk);
        chk(rd_data == held, "R13 output held on empty reads", 36'(rd_data), 36'(held));
        write_n(2, 100);
        settle();
        read_n(4, 100, "R13 pointer unmoved by empty reads");

        // R1 R2 R4 R7: random traffic, word, high end first, standard
        traffic(150, "R4 word random std");

        // R3 R5 R7: byte, low end first, standard
        master_reset(0, 0, 1, 2'd1);
        traffic(120, "R5 byte random std");
        write_n(16, 100);
        settle();
        chk(almost_empty == 1, "R10 ae at 16 with preset 16", 36'(almost_empty), 1);
        write_n(1, 100);
        settle();
        chk(almost_empty == 0, "R10 ae clear at 17 with preset 16", 36'(almost_empty), 0);
        read_n(17 * 4, 100, "R3 byte drain");

        // R8 R3 R4: fall-through, byte, high end first
        master_reset(1, 1, 1, 2'd3);
        chk(rflag == 0, "R8 not ready after reset", 36'(rflag), 0);
        chk(wflag == 1, "R8 input ready after reset", 36'(wflag), 1);
        write_n(1, 100);
        settle();
        chk(rflag == 1, "R8 ready without read", 36'(rflag), 1);
        chk(rd_data == next_piece(), "R8 head shown without read", 36'(rd_data), 36'(next_piece()));
        read_n(4, 100, "R3 fwft byte");
        traffic(120, "R4 byte random fwft");
        write_n(64, 100);
        settle();
        chk(almost_empty == 1, "R10 ae at 64 with preset 3", 36'(almost_empty), 1);
        write_n(1, 100);
        settle();
        chk(almost_empty == 0, "R10 ae clear at 65 with preset 3", 36'(almost_empty), 0);
        read_n(65 * 4, 100, "R3 fwft drain");

        // R12 R5 R2: fall-through, word, low end first, preset 0
        master_reset(1, 0, 0, 2'd0);
        traffic(120, "R5 word random fwft");
        write_n(8, 100);
        settle();
        chk(almost_empty == 1, "R10 ae at 8 with preset 0", 36'(almost_empty), 1);
        cfg_fwft = 0; cfg_big_end = 1; cfg_byte = 1; cfg_ofs_sel = 2'd2;
        prst_n = 0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        prst_n = 1;
        q.delete(); pidx = 0;
        settle();
        chk(rflag == 0, "R12 fall-through kept, not ready", 36'(rflag), 0);
        chk(wflag == 1, "R12 fall-through kept, input ready", 36'(wflag), 1);
        chk(almost_empty == 1, "R12 ae after flush", 36'(almost_empty), 1);
        write_n(9, 100);
        settle();
        chk(almost_empty == 0, "R12 offset 8 kept", 36'(almost_empty), 0);
        read_n(18, 100, "R12 word low-end-first kept");

        // R9 R10 R14 R13: fill, standard, preset 64
        master_reset(0, 1, 0, 2'd2);
        write_n(191, 100);
        settle();
        chk(almost_full == 0, "R9 af clear with 65 free", 36'(almost_full), 0);
        write_n(1, 100);
        settle();
        chk(almost_full == 1, "R9 af set with 64 free", 36'(almost_full), 1);
        write_n(63, 100);
        settle();
        chk(wflag == 0, "R14 not full at 255", 36'(wflag), 0);
        write_n(1, 100);
        settle();
        chk(wflag == 1, "R14 full at 256", 36'(wflag), 1);
        @(negedge wclk); wr_en = 1; wr_data = 36'hB_ADBA_DBAD;
        @(negedge wclk); wr_en = 0;
        settle();
        read_n(256 * 2, 100, "R13 data intact after write while full");
        settle();
        chk(rflag == 1, "R13 extra write not stored", 36'(rflag), 1);
        chk(almost_full == 0, "R9 af clear after drain", 36'(almost_full), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule